// File: doc/BRIEF.md
# External Bus Access Priority Arbiter

This block decides which of four requesters owns a single external bus. The requesters are an external device that asks to take the bus over (hold), CPU operand data transfers, CPU instruction fetches to a branch target, and CPU fetches of the next sequential instructions. The block keeps at most one grant asserted at a time and flags whether the bus is driven by the external device or by the CPU. Bus timing, address decoding and the data path belong to other blocks.

A grant is registered. Once given, it stays until the owning source pulses its `done` line, and arbitration then runs again on that same edge. Two lock inputs shape the choice. `seq_lock` is raised by the CPU for the whole of an access that needs several bus transfers, such as a misaligned word split into pieces; while it is high only operand data can win. `rmw_pending` is high in the gap between the read and the write of a read-modify-write; there only the hold request is held back, so an instruction fetch may still slip in. Requests are levels that stay high until served. The grant and request lines are plain control pins, because no data flows through the block and so no valid/ready handshake applies.

Top module: `bus_prio_arbiter`

## Requirements
- R1: During and directly after reset, `grant` is 4'b0000 and `ext_master` is 0.
- R2: When arbitration runs, the winner is the lowest-numbered eligible request bit: bit 0 hold, then bit 1 operand data, then bit 2 branch fetch, then bit 3 sequential fetch.
- R3: At most one bit of `grant` is high in any cycle.
- R4: `ext_master` is 1 exactly when the hold source (bit 0) holds the grant, and 0 when the CPU owns the bus or nothing is granted.
- R5: A grant is kept unchanged until `done` is pulsed on the granted bit. `done` pulses on bits that are not granted have no effect.
- R6: Arbitration runs when no grant is held or when the granted source pulses `done`. The new grant appears one clock edge later. The source that is completing is left out of that round, so another waiting request takes the bus back-to-back.
- R7: While `seq_lock` is high, arbitration can grant only operand data (bit 1). Hold and both fetch requests stay ungranted.
- R8: While `rmw_pending` is high, the hold request (bit 0) cannot win arbitration, but branch and sequential fetches still can.
- R9: With no eligible request, no grant is given and the CPU remains the default master (`ext_master` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 4 | Level requests: [0] hold, [1] operand data, [2] branch fetch, [3] sequential fetch |
| done | input | 4 | One-cycle completion pulse per source, same bit order |
| seq_lock | input | 1 | Multi-transfer access in progress; only operand data may be granted |
| rmw_pending | input | 1 | Between read and write of a read-modify-write; hold is masked |
| grant | output | 4 | One-hot grant, same bit order, registered |
| ext_master | output | 1 | 1 when the external device owns the bus |

## Verification
Every result of this block is due one clock edge after the inputs that cause it: requests, done pulses and lock levels sampled at a rising edge produce the new `grant` and `ext_master` right after that edge. The driver changes inputs on the falling edge and queues the expected grant for the coming rising edge. The monitor compares one queued item a short delay after each rising edge, so every comparison lands exactly one register stage after its stimulus. All 16 request patterns are taken from idle to cover the priority order, and short sequences cover holding a grant, back-to-back handover, and the two lock inputs.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int NUM_SRC    = 4;
  localparam int SRC_HOLD   = 0;
  localparam int SRC_DATA   = 1;
  localparam int SRC_BRANCH = 2;
  localparam int SRC_SEQ    = 3;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  localparam src_vec_t HOLD_BIT  = src_vec_t'(1) << SRC_HOLD;
  localparam src_vec_t DATA_BIT  = src_vec_t'(1) << SRC_DATA;
endpackage

// File: rtl/arb_eligible.sv
// Filters raw requests down to those allowed to compete this round.
module arb_eligible
  import bus_arb_pkg::*;
(
  input  src_vec_t req_i,
  input  src_vec_t finishing_i,
  input  logic     seq_lock_i,
  input  logic     rmw_pending_i,
  output src_vec_t eligible_o
);
  src_vec_t lock_mask;

  always_comb begin
    lock_mask = '1;
    if (rmw_pending_i) lock_mask = lock_mask & ~HOLD_BIT;
    if (seq_lock_i)    lock_mask = lock_mask & DATA_BIT;
    eligible_o = req_i & ~finishing_i & lock_mask;
  end
endmodule

// File: rtl/arb_fixed_pick.sv
// Lowest index wins; built from a running "someone above me asked" chain.
module arb_fixed_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] win_o
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign win_o[i]    = cand_i[i] & ~taken[i];
    assign taken[i+1]  = taken[i] | cand_i[i];
  end
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
  import bus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] req,
  input  logic [3:0] done,
  input  logic       seq_lock,
  input  logic       rmw_pending,
  output logic [3:0] grant,
  output logic       ext_master
);
  src_vec_t grant_q;
  src_vec_t finishing;
  src_vec_t eligible;
  src_vec_t winner;
  logic     arb_run;

  assign finishing = done & grant_q;
  assign arb_run   = (grant_q == '0) || (finishing != '0);

  arb_eligible u_elig (
    .req_i         (req),
    .finishing_i   (finishing),
    .seq_lock_i    (seq_lock),
    .rmw_pending_i (rmw_pending),
    .eligible_o    (eligible)
  );

  arb_fixed_pick #(.N(NUM_SRC)) u_pick (
    .cand_i (eligible),
    .win_o  (winner)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       grant_q <= '0;
    else if (arb_run) grant_q <= winner;
  end

  assign grant      = grant_q;
  assign ext_master = grant_q[SRC_HOLD];

  // R3: never two owners
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5: grant stays until its own done
  p_hold_until_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((done & grant) == '0)) |=> (grant == $past(grant)));

  // R6: an eligible request is never left waiting in a round
  p_serve_eligible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_run && (eligible != '0)) |=> (grant != '0));

  // R7: under seq_lock only operand data may be newly granted
  p_seq_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_run && seq_lock) |=> ((grant & ~DATA_BIT) == '0));

  // R8: hold cannot win inside a read-modify-write gap
  p_rmw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_run && rmw_pending) |=> !grant[SRC_HOLD]);

  // R9: nothing asked, nothing given
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_run && (req == '0)) |=> (grant == '0) && !ext_master);
endmodule

// File: tb/test_bus_prio_arbiter.sv
module test_bus_prio_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req = '0;
  logic [3:0] done = '0;
  logic       seq_lock = 1'b0;
  logic       rmw_pending = 1'b0;
  logic [3:0] grant;
  logic       ext_master;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  typedef struct {
    logic [3:0] g;
    logic       m;
    string      tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  bus_prio_arbiter i_bus_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .seq_lock(seq_lock), .rmw_pending(rmw_pending),
    .grant(grant), .ext_master(ext_master)
  );

  function automatic logic [3:0] prio_of(input logic [3:0] r);
    for (int i = 0; i < 4; i++)
      if (r[i]) return 4'b0001 << i;
    return 4'b0000;
  endfunction

  task automatic step(input logic [3:0] r, input logic [3:0] d,
                      input logic lk, input logic rmw,
                      input logic [3:0] eg, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; done = d; seq_lock = lk; rmw_pending = rmw;
    e.g = eg; e.m = eg[0]; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one item per rising edge, sampled after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (grant !== e.g || ext_master !== e.m) begin
          fails++;
          $display("FAIL %s: grant=%b ext_master=%b expected grant=%b ext_master=%b",
                   e.tag, grant, ext_master, e.g, e.m);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== 4'b0000 || ext_master !== 1'b0) begin
      fails++;
      $display("FAIL R1: grant=%b ext_master=%b expected 0000/0", grant, ext_master);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (grant !== 4'b0000 || ext_master !== 1'b0) begin
      fails++;
      $display("FAIL R1 after release: grant=%b ext_master=%b expected 0000/0",
               grant, ext_master);
    end

    // R2 R4 R9: every request pattern from idle, then release
    for (int p = 0; p < 16; p++) begin
      logic [3:0] w;
      w = prio_of(4'(p));
      step(4'(p), 4'b0000, 1'b0, 1'b0, w, (p == 0) ? "R9 idle" : "R2 R4 priority");
      step(4'b0000, w, 1'b0, 1'b0, 4'b0000, "R6 R9 release");
    end

    // R5: grant held, foreign done ignored; R6 back-to-back handover
    step(4'b1000, 4'b0000, 1'b0, 1'b0, 4'b1000, "R5 seq fetch granted");
    step(4'b1001, 4'b0001, 1'b0, 1'b0, 4'b1000, "R5 foreign done ignored");
    step(4'b1001, 4'b0000, 1'b0, 1'b0, 4'b1000, "R5 held while hold waits");
    step(4'b1001, 4'b1000, 1'b0, 1'b0, 4'b0001, "R6 handover to hold");
    step(4'b1000, 4'b0001, 1'b0, 1'b0, 4'b1000, "R6 handover back to fetch");
    step(4'b0000, 4'b1000, 1'b0, 1'b0, 4'b0000, "R9 back to idle");

    // R7: seq_lock lets only operand data through
    step(4'b1101, 4'b0000, 1'b1, 1'b0, 4'b0000, "R7 hold/fetch blocked");
    step(4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0010, "R7 data allowed");
    step(4'b1111, 4'b0010, 1'b1, 1'b0, 4'b0000, "R7 no fetch between pieces");
    step(4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0010, "R7 next piece");
    step(4'b1101, 4'b0010, 1'b0, 1'b0, 4'b0001, "R7 lock ended hold wins");
    step(4'b0000, 4'b0001, 1'b0, 1'b0, 4'b0000, "R4 hold released");

    // R8: rmw gap masks hold but lets fetches in
    step(4'b1001, 4'b0000, 1'b0, 1'b1, 4'b1000, "R8 seq fetch in rmw gap");
    step(4'b0101, 4'b1000, 1'b0, 1'b1, 4'b0100, "R8 branch fetch in rmw gap");
    step(4'b0001, 4'b0100, 1'b0, 1'b1, 4'b0000, "R8 hold alone masked");
    step(4'b0001, 4'b0000, 1'b0, 1'b0, 4'b0001, "R8 hold after gap");
    step(4'b0000, 4'b0001, 1'b0, 1'b0, 4'b0000, "R9 final idle");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule